// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits between a memory controller's command scheduler and its column address path. Software or an initialisation sequencer first loads a base configuration word through a mode-register write port. The word sets the burst length, the burst ordering, the CAS latency and the operating mode. Any word that contains a code the block does not accept is refused as a whole, and the refusal is flagged.

Once configured, each burst request carries a start column and a read/write flag. The block expands it into one column address per clock. Every beat of a burst stays inside a block of columns that is aligned to the burst length. The beats within that block follow either an incrementing order that wraps, or an order formed by XOR of the start offset with the beat count.

The same burst length and ordering apply to reads and to writes. The decoded CAS latency is presented continuously. A one-cycle pulse requests a DLL reset.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the configuration is burst length 4, sequential order and CAS latency 2, so `cas_half` reads 4.
- R2: Word bits [2:0] select the burst length. The code 001 gives 2 beats, 010 gives 4 beats and 011 gives 8 beats. Every other code is reserved.
- R3: Word bit 3 selects the ordering. A 0 selects sequential order and a 1 selects interleaved order, for reads and for writes alike.
- R4: During a burst of length N, every column bit at or above log2(N) equals that of the start column. Only the low log2(N) bits change, so the burst never leaves its aligned block.
- R5: In sequential order, beat k has low bits equal to (start offset + k) mod N. For example, N=4 starting at 2 gives 2, 3, 0, 1.
- R6: In interleaved order, beat k has low bits equal to start offset XOR k. For example, N=8 starting at 5 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R7: A mode write with `mr_bank` not equal to 2'b00 changes nothing. It produces neither an error pulse nor a DLL-reset pulse.
- R8: Word bits [6:4] select the CAS latency. The code 010 gives latency 2, reported as `cas_half`=4. The code 110 gives latency 2.5, reported as `cas_half`=5. Every other code is reserved.
- R9: Word bits [12:7] select the operating mode. All zeros means normal operation. The pattern 000010 (only word bit 8 set) means normal operation plus a DLL reset, and `dll_reset` is then high for exactly the one cycle after the write. Every other pattern is reserved. Word bits [14:13] must be zero, and any other value is reserved.
- R10: A base-register write that holds any reserved code leaves all fields unchanged. `mr_error` is then high for exactly the one cycle after the write.
- R11: A request accepted at a clock edge shows beat 0 in the following cycle, then one beat per cycle. `col_last` is high only on the final beat, and `col_write` carries the request's flag. While a burst is active, `busy` is high. A request seen while busy, including one on the final beat, raises `req_reject` in the same cycle and is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_we | input | 1 | Mode-register write strobe |
| mr_bank | input | 2 | Register select; only 2'b00 addresses the base register |
| mr_word | input | 15 | Configuration word |
| req_valid | input | 1 | Burst request |
| req_col | input | COL_W | Start column of the request |
| req_write | input | 1 | 1 for a write burst, 0 for a read burst |
| busy | output | 1 | A burst is in progress |
| req_reject | output | 1 | The current request is refused because a burst is in progress |
| col_valid | output | 1 | `col_addr` holds a beat |
| col_addr | output | COL_W | Column address of the current beat |
| col_write | output | 1 | Read/write flag of the current burst |
| col_last | output | 1 | Final beat of the burst |
| cas_half | output | 3 | Decoded CAS latency in half cycles |
| dll_reset | output | 1 | One-cycle DLL-reset request |
| mr_error | output | 1 | One-cycle flag for a refused configuration word |

## Verification
The embedded assertions check the following properties on every cycle:
- a refused word or a write to another bank leaves the configuration untouched;
- error and DLL pulses never coincide;
- a rejection only occurs while busy;
- the upper column bits and the read/write flag stay constant across a burst;
- the last beat is followed by an idle cycle.

The exact beat order can only be shown by the bench's scenarios, which compare every beat against an independent model. This covers sequential wrap, XOR order and the length decode. The same applies to the reset defaults, the CAS encoding and the rejection of each reserved field.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int MR_W  = 15;
    localparam int OFF_W = 3;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic [1:0]   len_lg;
        burst_order_e order;
        logic [2:0]   cas_half;
    } mode_cfg_t;

    typedef struct packed {
        logic      ok;
        logic      dll;
        mode_cfg_t cfg;
    } mode_dec_t;

    localparam mode_cfg_t CFG_RESET = '{len_lg: 2'd2, order: ORD_SEQ, cas_half: 3'd4};

    function automatic logic [OFF_W-1:0] len_mask(input logic [1:0] lg);
        case (lg)
            2'd1:    return 3'b001;
            2'd2:    return 3'b011;
            2'd3:    return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    function automatic mode_dec_t decode_mode(input logic [MR_W-1:0] w);
        mode_dec_t d;
        logic len_ok, cas_ok, op_ok;
        d = '0;
        len_ok = 1'b1;
        cas_ok = 1'b1;
        op_ok  = 1'b1;
        case (w[2:0])
            3'b001:  d.cfg.len_lg = 2'd1;
            3'b010:  d.cfg.len_lg = 2'd2;
            3'b011:  d.cfg.len_lg = 2'd3;
            default: len_ok = 1'b0;
        endcase
        d.cfg.order = burst_order_e'(w[3]);
        case (w[6:4])
            3'b010:  d.cfg.cas_half = 3'd4;
            3'b110:  d.cfg.cas_half = 3'd5;
            default: cas_ok = 1'b0;
        endcase
        if (w[12:7] == 6'b000000) begin
            d.dll = 1'b0;
        end else if (w[12:7] == 6'b000010) begin
            d.dll = 1'b1;
        end else begin
            op_ok = 1'b0;
        end
        d.ok = len_ok && cas_ok && op_ok && (w[14:13] == 2'b00);
        return d;
    endfunction

    function automatic logic [OFF_W-1:0] beat_offset(
        input logic [OFF_W-1:0] start,
        input logic [OFF_W-1:0] beat,
        input burst_order_e     ord,
        input logic [1:0]       lg
    );
        logic [OFF_W-1:0] raw;
        raw = (ord == ORD_ILV) ? (start ^ beat) : (start + beat);
        return raw & len_mask(lg);
    endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import burst_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [1:0]      bank,
    input  logic [MR_W-1:0] word,
    output mode_cfg_t       cfg,
    output logic            err_pulse,
    output logic            dll_pulse
);

    mode_dec_t dec;
    logic      hit;

    always_comb begin
        dec = decode_mode(word);
        hit = we && (bank == 2'b00);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= CFG_RESET;
            err_pulse <= 1'b0;
            dll_pulse <= 1'b0;
        end else begin
            err_pulse <= 1'b0;
            dll_pulse <= 1'b0;
            if (hit) begin
                if (dec.ok) begin
                    cfg       <= dec.cfg;
                    dll_pulse <= dec.dll;
                end else begin
                    err_pulse <= 1'b1;
                end
            end
        end
    end

    // R10: a refused word keeps every field
    p_err_keeps_cfg_r10: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (cfg == $past(cfg)));

    // R7: other bank selects have no effect
    p_bank_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (we && bank != 2'b00) |=> (cfg == $past(cfg)) && !err_pulse && !dll_pulse);

    // R9/R10: DLL pulse only on accepted words
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(err_pulse && dll_pulse));

    // R8: latency encoding limited to the two legal values
    p_cas_legal_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg.cas_half == 3'd4) || (cfg.cas_half == 3'd5));

endmodule

// File: rtl/bcs_burst_gen.sv
module bcs_burst_gen
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_write,
    input  logic [1:0]       cfg_len_lg,
    input  burst_order_e     cfg_order,
    output logic             busy,
    output logic             reject,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_write,
    output logic             col_last
);

    localparam int HI_W = COL_W - OFF_W;

    logic             active;
    logic [COL_W-1:0] base;
    logic [OFF_W-1:0] start_off;
    logic [OFF_W-1:0] beat;
    logic [1:0]       lg;
    burst_order_e     order;
    logic             wr;
    logic [OFF_W-1:0] req_mask;
    logic [OFF_W-1:0] off;
    logic             at_end;
    logic             accept;

    always_comb begin
        req_mask = len_mask(cfg_len_lg);
        accept   = req_valid && !active;
        off      = beat_offset(start_off, beat, order, lg);
        at_end   = (beat == len_mask(lg));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            base      <= '0;
            start_off <= '0;
            beat      <= '0;
            lg        <= 2'd2;
            order     <= ORD_SEQ;
            wr        <= 1'b0;
        end else if (accept) begin
            active    <= 1'b1;
            base      <= req_col & ~{{HI_W{1'b0}}, req_mask};
            start_off <= req_col[OFF_W-1:0] & req_mask;
            beat      <= '0;
            lg        <= cfg_len_lg;
            order     <= cfg_order;
            wr        <= req_write;
        end else if (active) begin
            if (at_end) begin
                active <= 1'b0;
            end
            beat <= beat + 3'd1;
        end
    end

    assign busy      = active;
    assign reject    = req_valid && active;
    assign col_valid = active;
    assign col_addr  = base | {{HI_W{1'b0}}, off};
    assign col_write = wr;
    assign col_last  = active && at_end;

    // R4: bits above the largest burst block never move inside a burst
    p_upper_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_last) |=> (col_addr[COL_W-1:OFF_W] == $past(col_addr[COL_W-1:OFF_W])));

    // R11: direction flag constant across the burst
    p_dir_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_last) |=> $stable(col_write));

    // R11: refusal only while a burst runs
    p_reject_busy_r11: assert property (@(posedge clk) disable iff (rst)
        reject |-> busy);

    // R11: final beat is followed by an idle cycle
    p_idle_after_last_r11: assert property (@(posedge clk) disable iff (rst)
        col_last |=> !col_valid);

    // R11: last flag only on a valid beat
    p_last_valid_r11: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mr_we,
    input  logic [1:0]       mr_bank,
    input  logic [14:0]      mr_word,
    input  logic             req_valid,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_write,
    output logic             busy,
    output logic             req_reject,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_write,
    output logic             col_last,
    output logic [2:0]       cas_half,
    output logic             dll_reset,
    output logic             mr_error
);

    mode_cfg_t cfg;

    bcs_mode_reg u_mode (
        .clk       (clk),
        .rst       (rst),
        .we        (mr_we),
        .bank      (mr_bank),
        .word      (mr_word),
        .cfg       (cfg),
        .err_pulse (mr_error),
        .dll_pulse (dll_reset)
    );

    bcs_burst_gen #(.COL_W(COL_W)) u_gen (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_col    (req_col),
        .req_write  (req_write),
        .cfg_len_lg (cfg.len_lg),
        .cfg_order  (cfg.order),
        .busy       (busy),
        .reject     (req_reject),
        .col_valid  (col_valid),
        .col_addr   (col_addr),
        .col_write  (col_write),
        .col_last   (col_last)
    );

    assign cas_half = cfg.cas_half;

endmodule

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic             mr_we;
    logic [1:0]       mr_bank;
    logic [14:0]      mr_word;
    logic             req_valid;
    logic [COL_W-1:0] req_col;
    logic             req_write;
    logic             busy, req_reject, col_valid, col_write, col_last;
    logic [COL_W-1:0] col_addr;
    logic [2:0]       cas_half;
    logic             dll_reset, mr_error;

    int n_checks = 0;
    int n_fail   = 0;
    int m_lg     = 2;
    int m_ilv    = 0;
    int m_cas    = 4;

    always #2 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
        .clk(clk), .rst(rst), .mr_we(mr_we), .mr_bank(mr_bank), .mr_word(mr_word),
        .req_valid(req_valid), .req_col(req_col), .req_write(req_write),
        .busy(busy), .req_reject(req_reject), .col_valid(col_valid),
        .col_addr(col_addr), .col_write(col_write), .col_last(col_last),
        .cas_half(cas_half), .dll_reset(dll_reset), .mr_error(mr_error)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // independent model of the configuration word
    function automatic bit word_ok(input logic [14:0] w, output int lg, output int cas, output bit dll);
        bit ok = 1;
        lg = 0; cas = 0; dll = 0;
        if (w[2:0] == 3'd1) lg = 1;
        else if (w[2:0] == 3'd2) lg = 2;
        else if (w[2:0] == 3'd3) lg = 3;
        else ok = 0;
        if (w[6:4] == 3'b010) cas = 4;
        else if (w[6:4] == 3'b110) cas = 5;
        else ok = 0;
        if (w[12:7] == 6'd0) dll = 0;
        else if (w[12:7] == 6'd2) dll = 1;
        else ok = 0;
        if (w[14:13] != 0) ok = 0;
        return ok;
    endfunction

    task automatic mode_write(input logic [1:0] bank, input logic [14:0] w);
        int lg, cas; bit dll, ok;
        bit exp_err = 0, exp_dll = 0;
        @(negedge clk);
        mr_we = 1; mr_bank = bank; mr_word = w;
        @(negedge clk);
        mr_we = 0;
        ok = word_ok(w, lg, cas, dll);
        if (bank == 2'b00) begin
            if (ok) begin
                m_lg = lg; m_ilv = w[3]; m_cas = cas; exp_dll = dll;
            end else begin
                exp_err = 1;
            end
        end
        check(bank != 0 ? "R7 error" : "R10 error", mr_error, exp_err);
        check(bank != 0 ? "R7 dll" : "R9 dll pulse", dll_reset, exp_dll);
        check("R8 cas", cas_half, m_cas);
        @(negedge clk);
        check("R10 error one cycle", mr_error, 0);
        check("R9 dll one cycle", dll_reset, 0);
    endtask

    task automatic run_burst(input int col, input bit wr, input bit inject);
        int n = 1 << m_lg;
        int s = col & (n - 1);
        int base = col & ~(n - 1) & ((1 << COL_W) - 1);
        @(negedge clk);
        req_valid = 1; req_col = col[COL_W-1:0]; req_write = wr;
        for (int b = 0; b < n; b++) begin
            int off;
            @(negedge clk);
            req_valid = 0;
            if (inject && b == 1) begin
                req_valid = 1;
                req_col = ~col[COL_W-1:0];
                req_write = ~wr;
            end
            #1;
            off = m_ilv ? (s ^ b) : ((s + b) % n);
            check(m_ilv ? "R6 addr" : "R5 addr", col_addr, base | off);
            check("R11 valid", col_valid, 1);
            check("R11 last", col_last, b == n - 1);
            check("R11 write flag", col_write, wr);
            check("R11 busy", busy, 1);
            check("R11 reject", req_reject, inject && b == 1);
        end
        @(negedge clk);
        req_valid = 0;
        #1;
        check("R11 idle after burst", col_valid, 0);
        check("R11 not busy", busy, 0);
    endtask

    function automatic logic [14:0] make_word(input int kind);
        logic [2:0] lenc;
        logic [2:0] casc;
        logic [5:0] op;
        logic [1:0] top;
        lenc = 3'($urandom_range(1, 3));
        casc = ($urandom % 2) ? 3'b110 : 3'b010;
        op   = ($urandom % 3 == 0) ? 6'b000010 : 6'b000000;
        top  = 2'b00;
        case (kind)
            1: lenc = 3'($urandom);
            2: casc = 3'($urandom);
            3: op   = 6'($urandom);
            4: top  = 2'($urandom);
            default: ;
        endcase
        return {top, op, casc, 1'($urandom), lenc};
    endfunction

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; mr_we = 0; mr_bank = 0; mr_word = 0;
        req_valid = 0; req_col = 0; req_write = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset defaults
        check("R1 cas reset", cas_half, 4);
        check("R1 idle reset", col_valid, 0);
        check("R1 no error", mr_error, 0);
        run_burst(10'h0a6, 0, 0);              // R1: 4 beats sequential, 6,7,4,5

        // R2/R5: length 2/4/8 sequential
        mode_write(2'b00, 15'b00_000000_010_0_001);
        run_burst(10'h3ff, 1, 0);
        mode_write(2'b00, 15'b00_000000_110_0_010);
        run_burst(10'h012, 0, 0);              // R5: 2,3,0,1
        mode_write(2'b00, 15'b00_000000_010_0_011);
        run_burst(10'h10d, 1, 1);              // R4 wrap in aligned block, R11 reject
        // R3/R6: interleaved length 8 start 5
        mode_write(2'b00, 15'b00_000000_010_1_011);
        run_burst(10'h2f5, 0, 0);              // R6: 5,4,7,6,1,0,3,2
        // R9 DLL reset
        mode_write(2'b00, 15'b00_000010_110_1_010);
        run_burst(10'h01b, 1, 0);
        // R10 reserved in each field
        mode_write(2'b00, 15'b00_000000_010_0_100);
        mode_write(2'b00, 15'b00_000000_011_0_001);
        mode_write(2'b00, 15'b00_000001_010_0_001);
        mode_write(2'b00, 15'b01_000000_010_0_001);
        run_burst(10'h01b, 0, 0);              // R10: config still len 4 ILV
        // R7 other bank
        mode_write(2'b01, 15'b00_000000_010_0_001);
        mode_write(2'b10, 15'b00_000010_010_0_011);
        run_burst(10'h155, 1, 0);

        // constrained random
        for (int i = 0; i < 120; i++) begin
            logic [1:0] bk;
            bk = ($urandom % 6 == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            mode_write(bk, make_word(int'($urandom % 6)));
            run_burst(int'($urandom % (1 << COL_W)), 1'($urandom), 1'($urandom % 4 == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule